// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces and checks the even parity bit of a PCI-style bus for an interface that can act as either initiator or target. Each clock it reduces the 32-bit address/data bus and the 4-bit command/byte-enable bus into one parity bit and registers it. In the following clock that bit appears on the parity output, and the parity output enable copies the address/data output enable from the previous clock. This gives the one-clock lag the bus requires.

A small phase tracker classifies every clock as an address phase driven by this unit, a data phase driven by this unit (initiator write, or target read), a data phase checked by this unit (target write), or idle. The tracker states are `ST_IDLE`, `ST_ADDR_OUT`, `ST_DATA_OUT` and `ST_DATA_CHK`. The tracker re-evaluates on every clock:
- An address phase while initiator leads to `ST_ADDR_OUT`.
- A valid data transfer as initiator of a write, or as target of a read, leads to `ST_DATA_OUT`.
- A valid data transfer as target of a write leads to `ST_DATA_CHK`.
- Anything else leads to `ST_IDLE`.

In `ST_DATA_CHK` the parity received on the bus is compared with the registered parity. A mismatch raises an error flag and sets a sticky status bit. An error reported on the external error input sets the same bit. While the bit is set and interrupts are enabled, a selector sends it to either an NMI-style or an SMI-style level output. Writing 1 to the clear strobe clears the bit.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_out` is 1 exactly when the number of ones in the 36 bits {ad, cbe} of the covered clock is odd, so that these bits plus the parity bit hold an even count. All bytes count, whatever the byte enables are.
- R2: `par_out` shows the parity of the bus values sampled at the previous rising edge, one clock late, in every clock including back-to-back phases.
- R3: `par_oe` equals `ad_oe` delayed by one clock.
- R4: A check happens only in the clock after a data transfer (`data_phase` and `xfer_valid`) with `is_initiator`=0 and `is_write`=1. Initiator transfers, read transfers, address phases and idle clocks never raise `par_err`, whatever `par_in` is.
- R5: In a checked clock, `par_err` is 1 when `par_in` differs from the parity of the previous clock's bus. The status bit `err_status` becomes 1 at the next edge.
- R6: `perr_ext`=1 sets `err_status` at the next edge, in the same way as an internal error.
- R7: `err_status` stays set until a clock with `status_clr`=1 and no new error. A new error in the same clock as a clear keeps the bit set.
- R8: When `irq_en`=1 and `err_status`=1, `route_smi`=0 asserts `nmi_out` and `route_smi`=1 asserts `smi_out`. Both outputs are levels, and both are 0 when `irq_en`=0 or `err_status`=0.
- R9: Reset makes `par_out`, `par_oe` and `err_status` 0, so parity is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad | input | 32 | Address/data bus value |
| cbe | input | 4 | Command/byte-enable bus value |
| ad_oe | input | 1 | This unit drives the address/data bus this clock |
| addr_phase | input | 1 | Current clock is an address phase |
| data_phase | input | 1 | Current clock is within a data phase |
| xfer_valid | input | 1 | Data transfer completes this clock |
| is_initiator | input | 1 | 1 = unit is initiator, 0 = target |
| is_write | input | 1 | 1 = write transaction, 0 = read |
| par_in | input | 1 | Parity received from the bus |
| perr_ext | input | 1 | Parity error reported by another agent |
| status_clr | input | 1 | Write-1 clear of the error status |
| irq_en | input | 1 | Enables the interrupt outputs |
| route_smi | input | 1 | 0 = route to NMI output, 1 = to SMI output |
| par_out | output | 1 | Delayed even parity |
| par_oe | output | 1 | Output enable for the parity line |
| par_err | output | 1 | Parity mismatch in the current checked clock |
| err_status | output | 1 | Sticky parity error status |
| nmi_out | output | 1 | NMI-style interrupt level |
| smi_out | output | 1 | SMI-style interrupt level |

## Verification
The hardest case is a checked clock: a target-write transfer has to be registered, and then a deliberately wrong `par_in` has to be presented in the very next clock, while the bus inputs are already changing. The bench drives one transfer clock and moves to idle bus values. It then sets `par_in` to the inverse of the independently computed parity of the earlier clock and samples `par_err` within that clock. The same `par_in` pattern is repeated after initiator-write and target-read transfers to show that no error is flagged. A clear is also issued in the same clock as a new error.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ADDR_OUT = 2'd1,
        ST_DATA_OUT = 2'd2,
        ST_DATA_CHK = 2'd3
    } par_state_e;
endpackage

// File: rtl/par_tree.sv
module par_tree #(
    parameter int W = 36
) (
    input  logic [W-1:0] vec,
    output logic         odd
);
    localparam int HALF = W / 2;
    logic [HALF:0] fold;
    // pairwise XOR stage, then reduce
    for (genvar i = 0; i < HALF; i++) begin : g_pair
        assign fold[i] = vec[2*i] ^ vec[2*i+1];
    end
    if (W % 2 == 1) begin : g_odd
        assign fold[HALF] = vec[W-1];
    end else begin : g_even
        assign fold[HALF] = 1'b0;
    end
    assign odd = ^fold;
endmodule

// File: rtl/par_phase_fsm.sv
module par_phase_fsm
    import pci_par_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_phase,
    input  logic       data_phase,
    input  logic       xfer_valid,
    input  logic       is_initiator,
    input  logic       is_write,
    output par_state_e state,
    output logic       chk_now
);
    par_state_e state_nx;
    logic       xfer;

    assign xfer = data_phase && xfer_valid;

    always_comb begin
        state_nx = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_ADDR_OUT, ST_DATA_OUT, ST_DATA_CHK: begin
                if (addr_phase && is_initiator)
                    state_nx = ST_ADDR_OUT;
                else if (xfer && (is_initiator == is_write))
                    state_nx = ST_DATA_OUT;
                else if (xfer && !is_initiator && is_write)
                    state_nx = ST_DATA_CHK;
                else
                    state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        chk_now = 1'b0;
        unique case (state)
            ST_DATA_CHK: chk_now = 1'b1;
            default:     chk_now = 1'b0;
        endcase
    end

    // R4: a check clock follows only a target-write transfer
    a_r4_chk_source: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !is_initiator && is_write && !(addr_phase && is_initiator)) |=> chk_now);
    a_r4_no_chk_other: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer && !is_initiator && is_write) |=> !chk_now);
endmodule

// File: rtl/par_err_status.sv
module par_err_status (
    input  logic clk,
    input  logic rst_n,
    input  logic err_int,
    input  logic err_ext,
    input  logic clr,
    input  logic irq_en,
    input  logic route_smi,
    output logic status,
    output logic nmi_out,
    output logic smi_out
);
    logic set_any;
    assign set_any = err_int || err_ext;

    always_ff @(posedge clk) begin
        if (!rst_n)       status <= 1'b0;
        else if (set_any) status <= 1'b1;
        else if (clr)     status <= 1'b0;
    end

    always_comb begin
        nmi_out = status && irq_en && !route_smi;
        smi_out = status && irq_en &&  route_smi;
    end

    // R7: sticky without clear
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr) |=> status);
    // R6 / R5: any error sets status
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_any |=> status);
    // R8: at most one interrupt output
    a_r8_one_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_out, smi_out}));
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad,
    input  logic [CBE_W-1:0] cbe,
    input  logic             ad_oe,
    input  logic             addr_phase,
    input  logic             data_phase,
    input  logic             xfer_valid,
    input  logic             is_initiator,
    input  logic             is_write,
    input  logic             par_in,
    input  logic             perr_ext,
    input  logic             status_clr,
    input  logic             irq_en,
    input  logic             route_smi,
    output logic             par_out,
    output logic             par_oe,
    output logic             par_err,
    output logic             err_status,
    output logic             nmi_out,
    output logic             smi_out
);
    localparam int PW = AD_W + CBE_W;

    logic       par_now;
    logic       chk_now;
    par_state_e state;

    par_tree #(.W(PW)) u_tree (
        .vec ( {ad, cbe}),
        .odd (par_now)
    );

    par_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_phase   (addr_phase),
        .data_phase   (data_phase),
        .xfer_valid   (xfer_valid),
        .is_initiator (is_initiator),
        .is_write     (is_write),
        .state        (state),
        .chk_now      (chk_now)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= par_now;
            par_oe  <= ad_oe;
        end
    end

    assign par_err = chk_now && (par_in != par_out);

    par_err_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_int   (par_err),
        .err_ext   (perr_ext),
        .clr       (status_clr),
        .irq_en    (irq_en),
        .route_smi (route_smi),
        .status    (err_status),
        .nmi_out   (nmi_out),
        .smi_out   (smi_out)
    );

    // R3: enable follows bus enable by one clock
    a_r3_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |=> par_oe);
    a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ad_oe |=> !par_oe);
    // R1 / R2: 36 bits of the previous clock plus parity hold an even count
    a_r1_even: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones({$past(ad), $past(cbe), par_out}) % 2 == 0));
    // R4: errors only in a check state
    a_r4_err_state: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> (state == ST_DATA_CHK));
endmodule

// File: tb/pci_parity_unit_bench.sv
module pci_parity_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] ad;
    logic [3:0]  cbe;
    logic ad_oe, addr_phase, data_phase, xfer_valid, is_initiator, is_write;
    logic par_in, perr_ext, status_clr, irq_en, route_smi;
    logic par_out, par_oe, par_err, err_status, nmi_out, smi_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // {ad, cbe, ad_oe}
    localparam logic [36:0] VEC [NV] = '{
        {32'h0000_0000, 4'h0, 1'b1},
        {32'h0000_0001, 4'h0, 1'b0},
        {32'hFFFF_FFFF, 4'hF, 1'b1},
        {32'h8000_0000, 4'h1, 1'b1},
        {32'hA5A5_0F0F, 4'h7, 1'b0},
        {32'h1234_5678, 4'h0, 1'b1}
    };

    pci_parity_unit u_pci_parity_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic exp_par(input logic [31:0] a, input logic [3:0] c);
        return logic'($countones({a, c}) % 2);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle_bus();
        addr_phase = 0; data_phase = 0; xfer_valid = 0;
        perr_ext = 0; status_clr = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; ad = '1; cbe = '1; ad_oe = 1; is_initiator = 0; is_write = 1;
        par_in = 0; irq_en = 1; route_smi = 0;
        idle_bus();
        tick(); tick();
        // R9 reset state
        check("R9 par_out", par_out, 1'b0);
        check("R9 par_oe", par_oe, 1'b0);
        check("R9 err_status", err_status, 1'b0);
        rst_n = 1; ad_oe = 0;

        // R1/R2/R3 table walk, back-to-back clocks
        for (int i = 0; i < NV; i++) begin
            ad = VEC[i][36:5]; cbe = VEC[i][4:1]; ad_oe = VEC[i][0];
            tick();
            check("R1/R2 par_out", par_out, exp_par(VEC[i][36:5], VEC[i][4:1]));
            check("R3 par_oe", par_oe, VEC[i][0]);
        end

        // R4: initiator write with a wrong par_in
        ad = 32'h0000_0003; cbe = 4'h0;
        is_initiator = 1; is_write = 1; data_phase = 1; xfer_valid = 1;
        tick(); idle_bus(); par_in = ~exp_par(32'h3, 4'h0); #1;
        check("R4 no check initiator write", par_err, 1'b0);
        // R4: target read
        is_initiator = 0; is_write = 0; data_phase = 1; xfer_valid = 1;
        tick(); idle_bus(); par_in = ~exp_par(32'h3, 4'h0); #1;
        check("R4 no check target read", par_err, 1'b0);
        // R4: address phase as initiator
        is_initiator = 1; is_write = 0; addr_phase = 1;
        tick(); idle_bus(); #1;
        check("R4 no check address", par_err, 1'b0);
        // R4: target write without xfer_valid
        is_initiator = 0; is_write = 1; data_phase = 1; xfer_valid = 0;
        tick(); idle_bus(); #1;
        check("R4 no check wait state", par_err, 1'b0);
        tick();
        check("R4 status untouched", err_status, 1'b0);

        // R5: target write with correct parity
        ad = 32'hDEAD_BEEF; cbe = 4'h5; data_phase = 1; xfer_valid = 1;
        tick(); idle_bus(); ad = 32'h1; par_in = exp_par(32'hDEAD_BEEF, 4'h5); #1;
        check("R5 good parity", par_err, 1'b0);
        tick();
        check("R5 status stays clear", err_status, 1'b0);

        // R5: target write with wrong parity, disabled bytes still counted (R1)
        ad = 32'hFF00_0000; cbe = 4'hE; data_phase = 1; xfer_valid = 1;
        tick(); idle_bus(); ad = 32'h0; par_in = ~exp_par(32'hFF00_0000, 4'hE); #1;
        check("R5 bad parity", par_err, 1'b1);
        check("R8 nmi before set", nmi_out, 1'b0);
        tick();
        check("R5 status set", err_status, 1'b1);
        check("R8 nmi_out", nmi_out, 1'b1);
        check("R8 smi_out off", smi_out, 1'b0);
        route_smi = 1; #1;
        check("R8 smi_out", smi_out, 1'b1);
        check("R8 nmi_out off", nmi_out, 1'b0);
        irq_en = 0; #1;
        check("R8 gated", smi_out | nmi_out, 1'b0);
        tick();
        check("R7 sticky", err_status, 1'b1);

        // R7: clear
        status_clr = 1; tick(); status_clr = 0;
        check("R7 cleared", err_status, 1'b0);

        // R6: external error
        perr_ext = 1; tick(); perr_ext = 0;
        check("R6 external", err_status, 1'b1);
        irq_en = 1; route_smi = 0; #1;
        check("R6 routed nmi", nmi_out, 1'b1);

        // R7: set and clear together keeps set
        status_clr = 1; perr_ext = 1; tick(); idle_bus();
        check("R7 set wins", err_status, 1'b1);
        status_clr = 1; tick(); status_clr = 0;
        check("R7 clear after", err_status, 1'b0);

        // R9: reset mid-run clears status and drive
        perr_ext = 1; ad_oe = 1; tick(); perr_ext = 0;
        rst_n = 0; tick();
        check("R9 reset status", err_status, 1'b0);
        check("R9 reset oe", par_oe, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule